// File: doc/BRIEF.md
# Crate Slave Register File

This block is the register file behind a slave module on a crate bus. A transaction arrives on a simple handshake port as one request cycle carrying four things: a primary address, a secondary address, a write flag and, for writes, the write data. The block decides whether the primary address selects this module. It does this in one of three ways: geographic (slot number), logical (a programmable address) or class broadcast (reads only). When the module is selected, the block performs a single read or write on the register that the secondary address names.

The register set has four parts:
- A control word that carries a fixed module identifier, an enable flag and a self-clearing module reset.
- A free 32-bit scratch register. It also holds the logical address.
- A 16-bit class register.
- One 8-bit discriminator threshold per channel, on a strided secondary-address map. An alias address loads every channel in one write.

Top module: `crate_reg_file`

## Requirements
- R1: After `rst_ni` is released, a geographic read of secondary 0 returns 0x00450000, and a read of secondary 7 returns 0.
- R2: A selected request is acknowledged with `ack_o` high for exactly one cycle, in the cycle after the request. `rdata_o` holds the read value in that cycle. An unselected request never raises `ack_o`.
- R3: Geographic mode (`mode_i`=0) selects the module when `paddr_i` equals `slot_i` zero-extended.
- R4: Logical mode (`mode_i`=1) selects the module only when the enable bit is set and `paddr_i` equals the register at secondary 3.
- R5: Broadcast mode (`mode_i`=2) selects the module for reads only, when `paddr_i` equals the class register zero-extended. Broadcast writes are not acknowledged and change nothing. Mode 3 never selects the module.
- R6: Secondary 0 reads as {16'h0045, 14'b0, enable, 1'b0}. In a write, data bit 1 set sets the enable bit and data bit 17 set clears it. If both are set, the clear wins. If neither is set, the enable bit is unchanged.
- R7: A write to secondary 0 with data bit 30 set clears the class register and every threshold. It leaves the enable bit and the register at secondary 3 unchanged, and bit 30 always reads back as 0.
- R8: Secondary 3 is a 32-bit register that reads back exactly what was written.
- R9: Secondary 7 stores data bits 15:0. Bits 31:16 read as 0.
- R10: The threshold of channel n (0..15) sits at secondary 0xC0000002 + 8·n. It stores data bits 7:0 and reads back zero-extended.
- R11: A write to secondary 0xC0000082 loads data bits 7:0 into all 16 thresholds. A read of that address returns 0.
- R12: At an unmapped secondary address, a selected write is acknowledged but changes no register, and a read returns 0. This covers misaligned threshold offsets and offsets past channel 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_i | input | 5 | Geographic slot number of this module |
| req_i | input | 1 | Transaction request, one cycle per transaction |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | Primary address mode: 0 geographic, 1 logical, 2 broadcast |
| paddr_i | input | 32 | Primary address |
| saddr_i | input | 32 | Secondary address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Acknowledge, one cycle after a selected request |

## Verification
The bench drives transactions in all three addressing modes with matching and non-matching primary addresses. Logical requests are sent both before and after the enable bit is set, and broadcast requests as both reads and writes. This separates a selection error from a data-path error.

Control-word writes use each combination of the set and clear bits, plus the reset bit. Each is followed by reads of the class register, the scratch register and the thresholds. This shows which state the reset touches and which it must leave alone.

Thresholds are written singly at the first, a middle and the last channel, through the all-channel alias, and at misaligned and out-of-range offsets. This exposes stride, width and range-decode faults.

// File: rtl/crf_pkg.sv
package crf_pkg;
  typedef enum logic [1:0] {
    AM_GEO   = 2'd0,
    AM_LOG   = 2'd1,
    AM_BCAST = 2'd2,
    AM_NONE  = 2'd3
  } amode_e;

  localparam logic [31:0] SA_CTRL  = 32'h0;
  localparam logic [31:0] SA_SCR   = 32'h3;
  localparam logic [31:0] SA_CLASS = 32'h7;

  localparam int CTRL_EN_SET = 1;
  localparam int CTRL_EN_CLR = 17;
  localparam int CTRL_RST    = 30;
endpackage

// File: rtl/crf_addr_match.sv
module crf_addr_match
  import crf_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  amode_e            mode_i,
  input  logic              we_i,
  input  logic [31:0]       paddr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              en_i,
  input  logic [31:0]       scr_i,
  input  logic [15:0]       class_i,
  output logic              hit_o
);
  always_comb begin
    unique case (mode_i)
      AM_GEO:   hit_o = (paddr_i == 32'(slot_i));
      AM_LOG:   hit_o = en_i && (paddr_i == scr_i);
      AM_BCAST: hit_o = !we_i && (paddr_i == 32'(class_i));
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crf_csr.sv
module crf_csr
  import crf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] saddr_i,
  input  logic [31:0] wdata_i,
  output logic        en_o,
  output logic [31:0] scr_o,
  output logic [15:0] class_o,
  output logic        mod_rst_o
);
  logic ctrl_wr;
  assign ctrl_wr   = wr_i && (saddr_i == SA_CTRL);
  assign mod_rst_o = ctrl_wr && wdata_i[CTRL_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      scr_o   <= '0;
      class_o <= '0;
    end else begin
      if (ctrl_wr) begin
        if (wdata_i[CTRL_EN_CLR])      en_o <= 1'b0;
        else if (wdata_i[CTRL_EN_SET]) en_o <= 1'b1;
      end
      if (wr_i && saddr_i == SA_SCR) scr_o <= wdata_i;
      if (mod_rst_o)                          class_o <= '0;
      else if (wr_i && saddr_i == SA_CLASS)   class_o <= wdata_i[15:0];
    end
  end

  // R6
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && saddr_i == SA_CTRL && wdata_i[CTRL_EN_SET] && !wdata_i[CTRL_EN_CLR]) |=> en_o);
  // R6
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && saddr_i == SA_CTRL && wdata_i[CTRL_EN_CLR]) |=> !en_o);
  // R7
  rst_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && saddr_i == SA_CTRL && wdata_i[CTRL_RST]) |=> (class_o == '0) && $stable(scr_o));
endmodule

// File: rtl/crf_thresh.sv
module crf_thresh #(
  parameter int          NUM_CH    = 16,
  parameter int          STRIDE_LG = 3,
  parameter logic [31:0] BASE      = 32'hC000_0002,
  parameter logic [31:0] ALL_ADDR  = 32'hC000_0082
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        clr_i,
  input  logic [31:0] saddr_i,
  input  logic [7:0]  wdata_i,
  output logic        rd_hit_o,
  output logic [7:0]  rd_val_o
);
  localparam int          IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [31:0] NUM_CH_W = 32'(NUM_CH);

  logic [31:0] off, idx;
  logic        wr_all;
  logic [7:0]  th_q [NUM_CH];

  assign off      = saddr_i - BASE;
  assign idx      = off >> STRIDE_LG;
  assign rd_hit_o = (off[STRIDE_LG-1:0] == '0) && (idx < NUM_CH_W);
  assign wr_all   = wr_i && (saddr_i == ALL_ADDR);
  assign rd_val_o = rd_hit_o ? th_q[idx[IDX_W-1:0]] : 8'h00;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          th_q[c] <= '0;
      else if (clr_i)                                       th_q[c] <= '0;
      else if (wr_all || (wr_i && rd_hit_o && idx == 32'(c))) th_q[c] <= wdata_i;
    end
  end

  // R11
  all_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && saddr_i == ALL_ADDR) |=>
      (th_q[0] == $past(wdata_i)) && (th_q[NUM_CH-1] == $past(wdata_i)));
  // R7
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (th_q[0] == '0) && (th_q[NUM_CH-1] == '0));
endmodule

// File: rtl/crate_reg_file.sv
module crate_reg_file
  import crf_pkg::*;
#(
  parameter int          SLOT_W  = 5,
  parameter logic [15:0] MOD_ID  = 16'h0045,
  parameter int          NUM_CH  = 16,
  parameter logic [31:0] TH_BASE = 32'hC000_0002,
  parameter logic [31:0] TH_ALL  = 32'hC000_0082
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        mode_i,
  input  logic [31:0]       paddr_i,
  input  logic [31:0]       saddr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ack_o
);
  logic        hit, wr, mod_rst, en, th_hit;
  logic [31:0] scr, rd_val;
  logic [15:0] cls;
  logic [7:0]  th_val;

  crf_addr_match #(.SLOT_W(SLOT_W)) u_match (
    .mode_i (amode_e'(mode_i)), .we_i(we_i), .paddr_i(paddr_i), .slot_i(slot_i),
    .en_i(en), .scr_i(scr), .class_i(cls), .hit_o(hit)
  );

  assign wr = req_i && we_i && hit;

  crf_csr u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .saddr_i(saddr_i), .wdata_i(wdata_i),
    .en_o(en), .scr_o(scr), .class_o(cls), .mod_rst_o(mod_rst)
  );

  crf_thresh #(.NUM_CH(NUM_CH), .STRIDE_LG(3), .BASE(TH_BASE), .ALL_ADDR(TH_ALL)) u_th (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .clr_i(mod_rst), .saddr_i(saddr_i),
    .wdata_i(wdata_i[7:0]), .rd_hit_o(th_hit), .rd_val_o(th_val)
  );

  always_comb begin
    if (saddr_i == SA_CTRL)       rd_val = {MOD_ID, 14'b0, en, 1'b0};
    else if (saddr_i == SA_SCR)   rd_val = scr;
    else if (saddr_i == SA_CLASS) rd_val = {16'b0, cls};
    else if (th_hit)              rd_val = {24'b0, th_val};
    else                          rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i && hit;
      rdata_o <= (req_i && !we_i && hit) ? rd_val : '0;
    end
  end

  // R2
  ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(req_i));
  // R3
  geo_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd0 && paddr_i == 32'(slot_i)) |=> ack_o);
  // R5
  bcast_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && mode_i == 2'd2) |=> !ack_o);
  // R6
  id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit && saddr_i == SA_CTRL) |=> (rdata_o[31:16] == MOD_ID) && !rdata_o[30]);
endmodule

// File: tb/crate_reg_file_bench.sv
`timescale 1ns/1ps
module crate_reg_file_bench;
  localparam logic [4:0] SLOT = 5'd12;
  localparam logic [31:0] THB = 32'hC000_0002;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] mode = 0;
  logic [31:0] pa = 0, sa = 0, wd = 0, rdata;
  logic ack;
  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_en;
  logic [31:0] m_scr;
  logic [15:0] m_cls;
  logic [7:0] m_th [16];

  always #2 clk = ~clk;

  crate_reg_file u_crate_reg_file (
    .clk_i(clk), .rst_ni(rst_n), .slot_i(SLOT), .req_i(req), .we_i(we), .mode_i(mode),
    .paddr_i(pa), .saddr_i(sa), .wdata_i(wd), .rdata_o(rdata), .ack_o(ack)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic bit m_sel(logic [1:0] md, bit w, logic [31:0] p);
    case (md)
      2'd0: return p == {27'b0, SLOT};
      2'd1: return m_en && p == m_scr;
      2'd2: return !w && p == {16'b0, m_cls};
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [31:0] s);
    logic [31:0] off = s - THB;
    if (s == 0) return {16'h0045, 14'b0, m_en, 1'b0};
    if (s == 3) return m_scr;
    if (s == 7) return {16'b0, m_cls};
    if (off[2:0] == 0 && (off >> 3) < 16) return {24'b0, m_th[off >> 3]};
    return 0;
  endfunction

  task automatic m_write(logic [31:0] s, logic [31:0] d);
    logic [31:0] off = s - THB;
    if (s == 0) begin
      if (d[17]) m_en = 0; else if (d[1]) m_en = 1;
      if (d[30]) begin m_cls = 0; foreach (m_th[i]) m_th[i] = 0; end
    end else if (s == 3) m_scr = d;
    else if (s == 7) m_cls = d[15:0];
    else if (s == 32'hC000_0082) foreach (m_th[i]) m_th[i] = d[7:0];
    else if (off[2:0] == 0 && (off >> 3) < 16) m_th[off >> 3] = d[7:0];
  endtask

  task automatic idle(string r);
    @(negedge clk);
    chk(r, {31'b0, ack}, 0);
  endtask

  // one transaction, compared against the model in the acknowledge cycle
  task automatic txn(string r, logic [1:0] md, bit w, logic [31:0] p, logic [31:0] s,
                     logic [31:0] d);
    bit e_ack = m_sel(md, w, p);
    logic [31:0] e_rd = m_read(s);
    req = 1; we = w; mode = md; pa = p; sa = s; wd = d;
    @(negedge clk);
    req = 0;
    chk({r, " ack"}, {31'b0, ack}, {31'b0, e_ack});
    if (e_ack && !w) chk({r, " rdata"}, rdata, e_rd);
    if (e_ack && w) m_write(s, d);
  endtask

  task automatic rd(string r, logic [31:0] s); txn(r, 0, 0, {27'b0, SLOT}, s, 0); endtask
  task automatic wr(string r, logic [31:0] s, logic [31:0] d); txn(r, 0, 1, {27'b0, SLOT}, s, d); endtask

  initial begin
    m_en = 0; m_scr = 0; m_cls = 0; foreach (m_th[i]) m_th[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R2 idle");
    rd("R1 ctrl", 0);
    chk("R1 ctrl id", rdata, 32'h0045_0000);
    rd("R1 class", 7);
    wr("R8", 3, 32'h1234_5678);
    rd("R8", 3);
    chk("R8 value", rdata, 32'h1234_5678);
    wr("R9", 7, 32'h8765_4321);
    rd("R9", 7);
    chk("R9 value", rdata, 32'h0000_4321);
    // R3 wrong slot
    txn("R3 miss", 0, 0, 32'd13, 0, 0);
    idle("R2 single");
    // R4 logical before enable
    txn("R4 disabled", 1, 0, 32'h1234_5678, 0, 0);
    wr("R9 class", 7, 32'h2);
    wr("R6 set", 0, 32'h2);
    rd("R6", 0);
    chk("R6 en set", rdata, 32'h0045_0002);
    txn("R4 logical", 1, 0, 32'h1234_5678, 0, 0);
    txn("R4 wrong", 1, 0, 32'h1234_5679, 0, 0);
    wr("R6 none", 0, 32'h0);
    rd("R6 hold", 0);
    wr("R6 both", 0, 32'h0002_0002);
    rd("R6 clr wins", 0);
    chk("R6 both", rdata, 32'h0045_0000);
    wr("R6 set2", 0, 32'h2);
    wr("R6 clr", 0, 32'h0002_0000);
    rd("R6", 0);
    txn("R5 bcast", 2, 0, 32'h2, 0, 0);
    txn("R5 bcast miss", 2, 0, 32'h3, 0, 0);
    txn("R5 bcast wr", 2, 1, 32'h2, 3, 32'hDEAD_BEEF);
    rd("R5 bcast wr no effect", 3);
    txn("R5 mode3", 3, 0, {27'b0, SLOT}, 0, 0);
    wr("R10 ch0", THB, 32'h1234_5678);
    rd("R10 ch0", THB);
    chk("R10 ch0 byte", rdata, 32'h78);
    wr("R10 ch7", THB + 8 * 7, 32'hA5);
    wr("R10 ch15", 32'hC000_007A, 32'h3C);
    rd("R10 ch15", 32'hC000_007A);
    rd("R10 ch7", THB + 8 * 7);
    rd("R10 ch1", THB + 8);
    // R7 reset
    wr("R6 set3", 0, 32'h2);
    wr("R7 rst", 0, 32'h4000_0000);
    rd("R7 ctrl", 0);
    chk("R7 bit30 low en kept", rdata, 32'h0045_0002);
    rd("R7 class", 7);
    rd("R7 th0", THB);
    rd("R7 scr", 3);
    chk("R7 scr kept", rdata, 32'h1234_5678);
    wr("R11 all", 32'hC000_0082, 32'h0000_0157);
    for (int c = 0; c < 16; c++) rd("R11 ch", THB + 8 * c);
    rd("R11 alias read", 32'hC000_0082);
    // R12 unmapped
    wr("R12 misaligned", THB + 1, 32'hFF);
    rd("R12 misaligned", THB + 1);
    rd("R12 ch0 intact", THB);
    wr("R12 sa4", 4, 32'hFFFF_FFFF);
    rd("R12 sa4", 4);
    rd("R12 scr intact", 3);
    rd("R12 low", THB - 8);
    idle("R2 idle end");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule